// File: doc/BRIEF.md
# Forward-Euler Second-Order ODE Engine

This block steps the equation y'' + 3·x·y' + 3·y = 0 forward in x with the explicit Euler rule. All values are signed fixed point with 16 integer and 16 fraction bits. A one-cycle `start` pulse captures the initial abscissa x, the value y, the slope u (= y'), the step dx and the upper limit a. The block then repeats the update body until the new abscissa is no longer below a. It then registers the final y on `y_out` and raises `done`.

The arithmetic runs on one shared multiplier and one shared ALU. The ALU can add, subtract and compare signed values (less-than). A sequencing FSM chooses the operands and the ALU operation for every cycle. Each pass through the update body takes six cycles.

The FSM schedules the work of one pass over its six cycles as follows:

| Cycle | Multiplier | ALU |
|-------|------------|-----|
| 0 | m1 = 3·x | xn = x + dx |
| 1 | m2 = u·dx | c = (xn < a) |
| 2 | m3 = m1·m2 | yn = y + m2 |
| 3 | m4 = 3·y | s = u − m3 |
| 4 | m5 = m4·dx | idle |
| 5 | idle | u ← s − m5, x ← xn, y ← yn |

Top module: `euler_ode_engine`

## Requirements
- R1: After synchronous reset, `done` is 0 and `y_out` is 0.
- R2: When the engine is idle, a `start` sampled high captures `x_in`, `y_in`, `u_in`, `dx_in` and `a_in` at that clock edge and clears `done` at the same edge.
- R3: Every multiply forms the full signed product and keeps product bits [47:16], which is the floor of the product divided by 2^16, taken modulo 2^32. Adds and subtracts wrap modulo 2^32. One pass computes, in this order:
  - m1 = 3.0·x
  - m2 = u·dx
  - m3 = m1·m2
  - m4 = 3.0·y
  - m5 = m4·dx
  - xn = x + dx
  - yn = y + m2
  - un = (u − m3) − m5

  At the end of the pass x, y and u take the values xn, yn and un.
- R4: The update body always runs at least once. After each pass, the loop runs again if xn < a (signed compare) and stops otherwise.
- R5: If the update body runs N times, `done` first reads 1 after the 6·N+1-th rising edge that follows the start edge. Until then it stays 0.
- R6: `y_out` changes only when a run finishes, and then it shows the final y. `y_out` and `done` hold their values until the next accepted start.
- R7: A `start` pulse while a run is in progress is ignored. The run's result, its latency and its captured operands are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the engine is idle |
| x_in | input | 32 | Initial x, signed 16.16 |
| y_in | input | 32 | Initial y, signed 16.16 |
| u_in | input | 32 | Initial y', signed 16.16 |
| dx_in | input | 32 | Step size, signed 16.16 |
| a_in | input | 32 | Upper limit on x, signed 16.16 |
| y_out | output | 32 | Final y, registered |
| done | output | 1 | High from the end of a run until the next accepted start |

## Verification
The assertions check on every cycle:
- the fixed six-step order inside a pass;
- that `done` only rises when the engine leaves its write-out state and stays high while no start arrives;
- that the state registers and `y_out` change only on a load, a commit or a write-out.

Only the bench scenarios can show the rest:
- the numeric result, checked against a behavioural fixed-point model;
- the exact latency for a single pass and for many passes;
- that a start pulse in the middle of a run has no effect.

// File: rtl/euler_pkg.sv
package euler_pkg;

  typedef enum logic [2:0] {
    MS_NONE,
    MS_3X,
    MS_UDX,
    MS_M1M2,
    MS_3Y,
    MS_M4DX
  } mul_sel_t;

  typedef enum logic [2:0] {
    AS_NONE,
    AS_XADD,
    AS_XLT,
    AS_YADD,
    AS_USUB,
    AS_FSUB
  } alu_sel_t;

  typedef enum logic [1:0] {
    OP_ADD,
    OP_SUB,
    OP_LT
  } alu_op_t;

  typedef enum logic [2:0] {
    ST_READ,
    ST_P0,
    ST_P1,
    ST_P2,
    ST_P3,
    ST_P4,
    ST_P5,
    ST_WRITE
  } state_t;

  function automatic alu_op_t alu_op_of(alu_sel_t s);
    case (s)
      AS_XLT:  return OP_LT;
      AS_USUB: return OP_SUB;
      AS_FSUB: return OP_SUB;
      default: return OP_ADD;
    endcase
  endfunction

endpackage

// File: rtl/euler_mul.sv
module euler_mul #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] full;

  always_comb begin
    a_ext = $signed({{W{op_a[W-1]}}, op_a});
    b_ext = $signed({{W{op_b[W-1]}}, op_b});
    full  = a_ext * b_ext;
    prod  = full[FRAC +: W];
  end
endmodule

// File: rtl/euler_alu.sv
module euler_alu
  import euler_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_t      op,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res,
  output logic         lt
);
  always_comb begin
    lt = ($signed(op_a) < $signed(op_b));
    case (op)
      OP_SUB:  res = op_a - op_b;
      OP_LT:   res = {{(W-1){1'b0}}, lt};
      default: res = op_a + op_b;
    endcase
  end
endmodule

// File: rtl/euler_ctrl.sv
module euler_ctrl
  import euler_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     c_flag,
  output mul_sel_t mul_sel,
  output alu_sel_t alu_sel,
  output logic     load,
  output logic     commit,
  output logic     wr,
  output logic     done
);
  state_t state, nxt;

  always_comb begin
    nxt     = state;
    mul_sel = MS_NONE;
    alu_sel = AS_NONE;
    load    = 1'b0;
    commit  = 1'b0;
    wr      = 1'b0;
    case (state)
      ST_READ: if (start) begin load = 1'b1; nxt = ST_P0; end
      ST_P0:   begin mul_sel = MS_3X;   alu_sel = AS_XADD; nxt = ST_P1; end
      ST_P1:   begin mul_sel = MS_UDX;  alu_sel = AS_XLT;  nxt = ST_P2; end
      ST_P2:   begin mul_sel = MS_M1M2; alu_sel = AS_YADD; nxt = ST_P3; end
      ST_P3:   begin mul_sel = MS_3Y;   alu_sel = AS_USUB; nxt = ST_P4; end
      ST_P4:   begin mul_sel = MS_M4DX;                    nxt = ST_P5; end
      ST_P5:   begin
        alu_sel = AS_FSUB;
        commit  = 1'b1;
        nxt     = c_flag ? ST_P0 : ST_WRITE;
      end
      ST_WRITE: begin wr = 1'b1; nxt = ST_READ; end
      default:  nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_READ;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (load)    done <= 1'b0;
      else if (wr) done <= 1'b1;
    end
  end

  // R5: a pass always walks its six steps in order, whatever start does
  assert_pass_order_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_P2) |=> (state == ST_P3));

  assert_p4_to_p5_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_P4) |=> (state == ST_P5));

  // R5: done only rises on leaving the write-out state
  assert_done_src_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state) == ST_WRITE));

  // R6: done holds while no start arrives
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R7: start during a run does not bring the engine back to idle
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_P0 && start) |=> (state == ST_P1));

endmodule

// File: rtl/euler_datapath.sv
module euler_datapath
  import euler_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  mul_sel_t     mul_sel,
  input  alu_sel_t     alu_sel,
  input  logic         load,
  input  logic         commit,
  input  logic         wr,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic         c_flag,
  output logic [W-1:0] y_out
);
  localparam logic [W-1:0] THREE = W'(3) << FRAC;

  logic [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  logic [W-1:0] xn_q, yn_q, s_q;
  logic [W-1:0] m1_q, m2_q, m3_q, m4_q, m5_q;

  logic [W-1:0] ma, mb, mp;
  logic [W-1:0] aa, ab, ares;
  logic         alt;
  alu_op_t      aop;

  always_comb begin
    case (mul_sel)
      MS_3X:   begin ma = THREE; mb = x_q;  end
      MS_UDX:  begin ma = u_q;   mb = dx_q; end
      MS_M1M2: begin ma = m1_q;  mb = m2_q; end
      MS_3Y:   begin ma = THREE; mb = y_q;  end
      MS_M4DX: begin ma = m4_q;  mb = dx_q; end
      default: begin ma = '0;    mb = '0;   end
    endcase
  end

  always_comb begin
    aop = alu_op_of(alu_sel);
    case (alu_sel)
      AS_XADD: begin aa = x_q;  ab = dx_q; end
      AS_XLT:  begin aa = xn_q; ab = a_q;  end
      AS_YADD: begin aa = y_q;  ab = m2_q; end
      AS_USUB: begin aa = u_q;  ab = m3_q; end
      AS_FSUB: begin aa = s_q;  ab = m5_q; end
      default: begin aa = '0;   ab = '0;   end
    endcase
  end

  euler_mul #(.W(W), .FRAC(FRAC)) u_mul (.op_a(ma), .op_b(mb), .prod(mp));
  euler_alu #(.W(W)) u_alu (.op(aop), .op_a(aa), .op_b(ab), .res(ares), .lt(alt));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0; u_q <= '0; dx_q <= '0; a_q <= '0;
      xn_q <= '0; yn_q <= '0; s_q <= '0;
      m1_q <= '0; m2_q <= '0; m3_q <= '0; m4_q <= '0; m5_q <= '0;
      c_flag <= 1'b0;
      y_out  <= '0;
    end else begin
      if (load) begin
        x_q <= x_in; y_q <= y_in; u_q <= u_in; dx_q <= dx_in; a_q <= a_in;
      end
      case (mul_sel)
        MS_3X:   m1_q <= mp;
        MS_UDX:  m2_q <= mp;
        MS_M1M2: m3_q <= mp;
        MS_3Y:   m4_q <= mp;
        MS_M4DX: m5_q <= mp;
        default: ;
      endcase
      case (alu_sel)
        AS_XADD: xn_q   <= ares;
        AS_XLT:  c_flag <= alt;
        AS_YADD: yn_q   <= ares;
        AS_USUB: s_q    <= ares;
        default: ;
      endcase
      if (commit) begin
        x_q <= xn_q;
        y_q <= yn_q;
        u_q <= ares;
      end
      if (wr) y_out <= y_q;
    end
  end

  // R7: working state moves only on a load or a commit
  assert_x_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(load || commit) |=> $stable(x_q));

  assert_u_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(load || commit) |=> $stable(u_q));

  // R6: the result port moves only at write-out
  assert_yout_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(y_out));

endmodule

// File: rtl/euler_ode_engine.sv
module euler_ode_engine
  import euler_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] y_out,
  output logic         done
);
  mul_sel_t mul_sel;
  alu_sel_t alu_sel;
  logic     load, commit, wr, c_flag;

  euler_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .c_flag(c_flag),
    .mul_sel(mul_sel), .alu_sel(alu_sel),
    .load(load), .commit(commit), .wr(wr), .done(done)
  );

  euler_datapath #(.W(W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rst(rst),
    .mul_sel(mul_sel), .alu_sel(alu_sel),
    .load(load), .commit(commit), .wr(wr),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .c_flag(c_flag), .y_out(y_out)
  );
endmodule

// File: tb/euler_ode_engine_tb.sv
module euler_ode_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ONE = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic [31:0] y_out;
  logic        done;

  int total = 0;
  int failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  euler_ode_engine u_dut (
    .clk(clk), .rst(rst), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .y_out(y_out), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [31:0] fmul(logic signed [31:0] a, logic signed [31:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return 32'(p >>> 16);
  endfunction

  // R3 R4 reference model: returns final y, gives pass count
  function automatic logic [31:0] model(logic signed [31:0] x0, logic signed [31:0] y0,
                                        logic signed [31:0] u0, logic signed [31:0] dx,
                                        logic signed [31:0] a, output int n);
    logic signed [31:0] x, y, u, m1, m2, m3, m4, m5, xn;
    logic c;
    x = x0; y = y0; u = u0; n = 0;
    do begin
      m1 = fmul(32'sd3 * ONE, x);
      m2 = fmul(u, dx);
      m3 = fmul(m1, m2);
      m4 = fmul(32'sd3 * ONE, y);
      m5 = fmul(m4, dx);
      xn = x + dx;
      c  = (xn < a);
      u  = (u - m3) - m5;
      y  = y + m2;
      x  = xn;
      n++;
    end while (c && n < 5000);
    return y;
  endfunction

  task automatic run_case(input string name, input logic [31:0] xi, yi, ui, dxi, ai, input int poke);
    int n, lat, moved;
    logic [31:0] ey, prev;
    ey = model(xi, yi, ui, dxi, ai, n);
    prev = y_out;
    lat = -1;
    moved = 0;
    @(negedge clk);
    x_in = xi; y_in = yi; u_in = ui; dx_in = dxi; a_in = ai; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= 6 * n + 40 && lat < 0; cyc++) begin
      if (cyc == poke) begin
        start = 1'b1; x_in = 32'h0003_0000; y_in = 32'hFFF0_0000; dx_in = 32'h0000_0100;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) lat = cyc;
      else if (y_out != prev) moved++;
    end
    chk("R5", {name, " latency"}, lat, 6 * n + 1);
    chk("R6", {name, " y_out held during run"}, moved, 0);
    chk(poke > 0 ? "R7" : "R3", {name, " y_out"}, longint'(y_out), longint'(ey));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    logic [31:0] hold_y;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "done after reset", done, 0);
    chk("R1", "y_out after reset", y_out, 0);

    // R4: single pass, x+dx already past a
    run_case("single", 32'd0, ONE, 32'd0, ONE / 2, ONE / 4, 0);
    // R4: sixteen passes
    run_case("many", 32'd0, ONE, 32'd0, ONE / 32, ONE / 2, 0);
    // R3: negative operands
    run_case("neg", -ONE, -(ONE / 2), 3 * ONE / 4, ONE / 8, 32'd0, 0);

    // R6: done and y_out hold over idle cycles
    hold_y = y_out;
    repeat (12) @(negedge clk);
    chk("R6", "done held", done, 1);
    chk("R6", "y_out held", y_out, hold_y);

    // R7: start mid-run ignored
    run_case("busy_start", 32'd0, ONE, ONE / 4, ONE / 32, ONE / 2, 9);

    // R2: new start clears done at its edge
    @(negedge clk);
    x_in = 0; y_in = ONE; u_in = 0; dx_in = ONE / 16; a_in = ONE;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done cleared by start", done, 0);
    repeat (6 * 16 + 4) @(negedge clk);
    chk("R2", "second run completes", done, 1);

    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule